// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides whether a frame is kept, looking only at its 48-bit destination address. The address arrives as six bytes with a valid strobe. Byte 0 is the first byte on the wire and sits in bits 7:0 of `addr_bytes`, and byte 5 sits in bits 47:40. One cycle later the block returns a result strobe, an accept flag and the index of the exact-match entry that hit.

Three mechanisms decide the result. The first is a bank of eight exact-match entries, where entry 0 is meant for the station's own unicast address. The second is a 64-bin multicast hash table indexed by a six-bit XOR fold of the address. The third is a set of mode controls: promiscuous, hash enable and broadcast block. A simple write port loads all of this state. A write takes effect on the cycle after it is presented.

Top module: `rx_dest_filter`

## Requirements
- R1: The write port holds the configuration. Entry e's low word is at offset 2e and packs address bytes 3,2,1,0 from bit 31 down to bit 0. Its high word is at offset 2e+1 and holds byte 5 in bits 15:8 and byte 4 in bits 7:0. The hash low word is at offset 16, the hash high word at 17, and the control at 18. A lookup whose address equals a programmed entry is accepted and reports that entry's index.
- R2: When several exact entries match, the lowest matching index is reported.
- R3: An entry whose low and high words are both zero never matches, so the all-zero address is not accepted through it.
- R4: A unicast address (byte 0 bit 0 clear) is accepted only through an exact match or promiscuous mode. This holds even when its hash bin is set.
- R5: When control bit 1 (hash enable) is set, a multicast address (byte 0 bit 0 set) is accepted if its hash bin is set. Address bit k = 8*byte + bit is XORed into bin bit k mod 6. Bins 0 to 31 are bits of the low hash word and bins 32 to 63 are bits 0 to 31 of the high hash word.
- R6: With control bit 1 clear, the hash table has no effect.
- R7: With control bit 0 (promiscuous) set, every address is accepted. The index still reports the lowest exact match, or all ones when no entry matches.
- R8: With control bit 2 (broadcast block) set and promiscuous clear, the all-ones address is rejected. With bit 2 clear, the all-ones address follows the normal rules; its hash bin is 0.
- R9: `res_valid` is high exactly in the cycle after `addr_valid`. `res_accept` is 0 whenever `res_valid` is 0. A rejected lookup reports an index of all ones (4'hF).
- R10: After reset, all entries, hash words and controls are zero, `res_valid` and `res_accept` are 0, and `res_index` is all ones.
- R11: A lookup presented in the same cycle as a configuration write is decided on the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word offset |
| cfg_wdata | input | 32 | Configuration write data |
| addr_valid | input | 1 | Destination address present |
| addr_bytes | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result strobe, one cycle after addr_valid |
| res_accept | output | 1 | Frame accepted |
| res_index | output | 4 | Lowest matching exact entry, all ones on a miss |

## Verification
A configuration write and a lookup can fall in the same cycle. In that case the lookup must be judged on the filter state from before the write. The bench provokes this by loading an entry's high word first. It then drives the low word that completes the entry in the same cycle as a lookup of that address, and expects a rejection. A lookup of the same address in the next cycle must then be accepted with the new entry's index. The scoreboard also drives lookups back to back across mode changes, so a stale or early control value shows up as a mismatch.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
  localparam int MAC_W  = 48;
  localparam int WORD_W = 32;
  localparam int HASH_W = 6;
  localparam int BINS   = 1 << HASH_W;

  localparam int CTL_PROMISC = 0;
  localparam int CTL_HASH_EN = 1;
  localparam int CTL_BC_BLK  = 2;

  typedef struct packed {
    logic bc_block;
    logic hash_en;
    logic promisc;
  } filt_ctrl_t;
endpackage

// File: rtl/rx_dest_filter_regs.sv
module rx_dest_filter_regs
  import rx_dest_filter_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int AW      = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [AW-1:0]                   waddr,
  input  logic [WORD_W-1:0]               wdata,
  output logic [N_EXACT-1:0][WORD_W-1:0]  ent_lo,
  output logic [N_EXACT-1:0][15:0]        ent_hi,
  output logic [BINS-1:0]                 hash_tbl,
  output filt_ctrl_t                      ctrl
);
  logic [N_EXACT-1:0][WORD_W-1:0] lo_q, lo_d;
  logic [N_EXACT-1:0][15:0]       hi_q, hi_d;
  logic [BINS-1:0]                hash_q, hash_d;
  filt_ctrl_t                     ctrl_q, ctrl_d;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    hash_d = hash_q;
    ctrl_d = ctrl_q;
    for (int e = 0; e < N_EXACT; e++) begin
      if (waddr == AW'(2 * e))     lo_d[e] = wdata;
      if (waddr == AW'(2 * e + 1)) hi_d[e] = wdata[15:0];
    end
    if (waddr == AW'(2 * N_EXACT))     hash_d[WORD_W-1:0]    = wdata;
    if (waddr == AW'(2 * N_EXACT + 1)) hash_d[BINS-1:WORD_W] = wdata;
    if (waddr == AW'(2 * N_EXACT + 2)) begin
      ctrl_d.promisc  = wdata[CTL_PROMISC];
      ctrl_d.hash_en  = wdata[CTL_HASH_EN];
      ctrl_d.bc_block = wdata[CTL_BC_BLK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      hash_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      hash_q <= hash_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ent_lo   = lo_q;
  assign ent_hi   = hi_q;
  assign hash_tbl = hash_q;
  assign ctrl     = ctrl_q;
endmodule

// File: rtl/rx_dest_filter_hash.sv
module rx_dest_filter_hash
  import rx_dest_filter_pkg::*;
(
  input  logic [MAC_W-1:0]  key,
  output logic [HASH_W-1:0] bin
);
  // Wire-order fold: bit k of the address lands in bin bit k mod HASH_W.
  always_comb begin
    bin = '0;
    for (int k = 0; k < MAC_W; k++) begin
      bin[k % HASH_W] = bin[k % HASH_W] ^ key[k];
    end
  end
endmodule

// File: rtl/rx_dest_filter_exact.sv
module rx_dest_filter_exact
  import rx_dest_filter_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int IDX_W   = 4
) (
  input  logic [MAC_W-1:0]                key,
  input  logic [N_EXACT-1:0][WORD_W-1:0]  ent_lo,
  input  logic [N_EXACT-1:0][15:0]        ent_hi,
  output logic                            hit,
  output logic [IDX_W-1:0]                hit_idx
);
  logic [N_EXACT-1:0] hit_vec;

  for (genvar g = 0; g < N_EXACT; g++) begin : g_cmp
    logic armed;
    assign armed      = |{ent_hi[g], ent_lo[g]};
    assign hit_vec[g] = armed && (key == {ent_hi[g], ent_lo[g]});
  end

  always_comb begin
    hit     = |hit_vec;
    hit_idx = '1;
    for (int e = N_EXACT - 1; e >= 0; e--) begin
      if (hit_vec[e]) hit_idx = IDX_W'(e);
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int N_EXACT = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(2*N_EXACT+3)-1:0]     cfg_addr,
  input  logic [31:0]                        cfg_wdata,
  input  logic                               addr_valid,
  input  logic [47:0]                        addr_bytes,
  output logic                               res_valid,
  output logic                               res_accept,
  output logic [$clog2(N_EXACT):0]           res_index
);
  localparam int IDX_W = $clog2(N_EXACT) + 1;
  localparam int AW    = $clog2(2 * N_EXACT + 3);

  logic [N_EXACT-1:0][WORD_W-1:0] ent_lo;
  logic [N_EXACT-1:0][15:0]       ent_hi;
  logic [BINS-1:0]                hash_tbl;
  filt_ctrl_t                     ctrl;
  logic [HASH_W-1:0]              bin;
  logic                           hit;
  logic [IDX_W-1:0]               hit_idx;

  logic ctrl_promisc, ctrl_bc_block;
  logic is_group, is_bcast, hash_ok, take;

  logic             valid_q, valid_d;
  logic             acc_q, acc_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  rx_dest_filter_regs #(.N_EXACT(N_EXACT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .hash_tbl(hash_tbl), .ctrl(ctrl)
  );

  rx_dest_filter_hash u_hash (.key(addr_bytes), .bin(bin));

  rx_dest_filter_exact #(.N_EXACT(N_EXACT), .IDX_W(IDX_W)) u_exact (
    .key(addr_bytes), .ent_lo(ent_lo), .ent_hi(ent_hi), .hit(hit), .hit_idx(hit_idx)
  );

  assign ctrl_promisc  = ctrl.promisc;
  assign ctrl_bc_block = ctrl.bc_block;

  always_comb begin
    is_group = addr_bytes[0];
    is_bcast = &addr_bytes;
    hash_ok  = ctrl.hash_en && is_group && hash_tbl[bin];
    take     = ctrl_promisc || (!(is_bcast && ctrl_bc_block) && (hit || hash_ok));
    valid_d  = addr_valid;
    acc_d    = addr_valid && take;
    idx_d    = (take && hit) ? hit_idx : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '1;
    end else if (addr_valid) begin
      idx_q <= idx_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = acc_q;
  assign res_index  = idx_q;
endmodule

// File: rtl/rx_dest_filter_checker.sv
module rx_dest_filter_checker #(
  parameter int N_EXACT = 8,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_valid,
  input logic [47:0]      addr_bytes,
  input logic             res_valid,
  input logic             res_accept,
  input logic [IDX_W-1:0] res_index,
  input logic             ctrl_promisc,
  input logic             ctrl_bc_block
);
  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> res_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !res_valid);

  assert_quiet_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_accept);

  assert_miss_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (res_index == {IDX_W{1'b1}}));

  assert_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_accept && res_index != {IDX_W{1'b1}}) |-> (int'(res_index) < N_EXACT));

  assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && ctrl_promisc) |=> res_accept);

  assert_bcast_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (&addr_bytes) && ctrl_bc_block && !ctrl_promisc) |=> !res_accept);
endmodule

bind rx_dest_filter rx_dest_filter_checker #(.N_EXACT(N_EXACT), .IDX_W(IDX_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_bytes(addr_bytes),
  .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index),
  .ctrl_promisc(ctrl_promisc), .ctrl_bc_block(ctrl_bc_block)
);

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;
  localparam logic [3:0]  MISS = 4'hF;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STA = 48'h6655_4433_2210;
  localparam logic [47:0] A3  = 48'h0A0B_0C0D_0E02;
  localparam logic [47:0] A7  = 48'h1234_5678_9A0C;
  localparam logic [47:0] A6  = 48'hDEAD_BEEF_0042;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        addr_valid;
  logic [47:0] addr_bytes;
  logic        res_valid;
  logic        res_accept;
  logic [3:0]  res_index;

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .addr_valid(addr_valid), .addr_bytes(addr_bytes),
    .res_valid(res_valid), .res_accept(res_accept), .res_index(res_index)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int e, input logic [47:0] a);
    wr(5'(2 * e), a[31:0]);
    wr(5'(2 * e + 1), {16'h0, a[47:32]});
  endtask

  task automatic look(input logic [47:0] a, input logic acc, input logic [3:0] idx,
                      input string tag);
    addr_valid = 1'b1; addr_bytes = a;
    q_exp.push_back({acc, idx}); q_tag.push_back(tag);
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  // Scoreboard monitor: every result is compared with the oldest expectation.
  always @(negedge clk) begin : mon
    logic [4:0] e;
    string t;
    if (rst_n && res_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R9", "unexpected result", 1, 0);
      end else begin
        e = q_exp.pop_front(); t = q_tag.pop_front();
        check(res_accept == e[4], t, "accept", res_accept, e[4]);
        check(res_index == e[3:0], t, "index", res_index, e[3:0]);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    addr_valid = 1'b0; addr_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R10", "reset valid", res_valid, 0);
    check(res_accept == 1'b0, "R10", "reset accept", res_accept, 0);
    check(res_index == MISS, "R10", "reset index", res_index, MISS);

    // R3 / R10: cleared entries and controls reject everything
    look(48'h0, 1'b0, MISS, "R3");
    look(48'h1, 1'b0, MISS, "R10");

    prog(0, STA);
    prog(3, A3);
    prog(5, A3);
    prog(7, A7);
    // back-to-back lookups (R9) over exact matches
    look(STA, 1'b1, 4'd0, "R1");
    look(A3, 1'b1, 4'd3, "R2");
    look(A7, 1'b1, 4'd7, "R1");
    look(48'h6655_4433_2212, 1'b0, MISS, "R4");
    look(48'h0, 1'b0, MISS, "R3");
    repeat (2) @(negedge clk);
    check(res_valid == 1'b0 && res_accept == 1'b0, "R9", "idle outputs",
          {res_valid, res_accept}, 0);

    // Hash: bin 5 (low word bit 5) and bin 33 (high word bit 1)
    wr(5'd16, 32'h0000_0020);
    wr(5'd17, 32'h0000_0002);
    wr(5'd18, 32'h2);
    look(48'h101, 1'b1, MISS, "R5");   // bits 0 and 8 -> bin 5
    look(48'h21, 1'b1, MISS, "R5");    // bits 0 and 5 -> bin 33
    look(48'h1, 1'b0, MISS, "R5");     // bin 1 not set
    look(48'h44, 1'b0, MISS, "R4");    // unicast in bin 5
    wr(5'd18, 32'h0);
    look(48'h101, 1'b0, MISS, "R6");

    // Broadcast and all-multicast
    wr(5'd16, 32'hFFFF_FFFF);
    wr(5'd17, 32'hFFFF_FFFF);
    wr(5'd18, 32'h6);
    look(BCAST, 1'b0, MISS, "R8");
    wr(5'd18, 32'h2);
    look(BCAST, 1'b1, MISS, "R8");
    look(48'hABCD_0000_0003, 1'b1, MISS, "R5");
    look(48'h10, 1'b0, MISS, "R4");

    // Promiscuous
    wr(5'd18, 32'h7);
    look(BCAST, 1'b1, MISS, "R7");
    look(48'h12, 1'b1, MISS, "R7");
    look(STA, 1'b1, 4'd0, "R7");

    // Write and lookup in the same cycle: the old contents decide
    wr(5'd18, 32'h0);
    wr(5'd13, {16'h0, A6[47:32]});
    cfg_we = 1'b1; cfg_addr = 5'd12; cfg_wdata = A6[31:0];
    addr_valid = 1'b1; addr_bytes = A6;
    q_exp.push_back({1'b0, MISS}); q_tag.push_back("R11");
    @(negedge clk);
    cfg_we = 1'b0; addr_valid = 1'b0;
    look(A6, 1'b1, 4'd6, "R11");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R9", "missing results", q_exp.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule